// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block decides which analog channel a successive-approximation converter samples next, and when. The converter sits behind a handshake. The sequencer pulses `conv_start` with a channel number. Some cycles later the converter answers with a one-cycle `conv_done` and a 10-bit result. The sequencer files each result into one of eight result slots, keeps a busy flag and an end-of-conversion flag, and raises an interrupt pulse once a group of results is complete. Software reaches it through a small register port. Writes take effect on the clock edge. Reads are combinational, and reading the status register clears its sticky flags.

Normal operation has four modes. A two-bit mode field `{rep, scan}` selects a single conversion of one channel, a single ascending sweep over channels, an endless repetition of one channel, or endless sweeps. When one channel repeats, a two-bit pacing field makes the interrupt fire after every 1, 4 or 8 results, and the results rotate through the matching number of slots. Separately, a priority request converts one chosen channel exactly once. It waits only for a conversion already in flight, then goes ahead of the normal sequence. It has its own result register, done flag, busy flag and interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Register map: address 0 holds control, with bit0 scan, bit1 rep, bits[3:2] pacing, bits[7:4] channel, and bit8 a start strobe that reads back as 0. Address 2 is status, with bit0 busy, bit1 eoc, bit2 priority busy and bit3 priority done. After reset all flags and outputs are 0. With mode 00, a start converts the channel field once, stores the result in slot 0, sets eoc, pulses `irq_norm` and clears busy.
- R2: With mode 01, a start converts channels 0 up to the channel field (capped at 7) in ascending order. Each result goes to the slot equal to its channel, slot k being readable at address 8+k. eoc and one `irq_norm` follow the last channel, and busy then clears.
- R3: With mode 10 and pacing 00, every result overwrites slot 0 and each result raises `irq_norm`.
- R4: With mode 10, pacing 01 stores into slots 0..3 in turn and wraps, with `irq_norm` after each 4th result. Pacing 10 does the same over slots 0..7, with `irq_norm` after each 8th result.
- R5: With mode 11, sweeps repeat with no end. Each finished sweep raises `irq_norm`, and busy stays 1 between conversions.
- R6: eoc rises in the same cycle as `irq_norm` and is cleared by a status read. If a read and a set fall in the same cycle, the set wins.
- R7: Clearing the rep bit during a repeat run lets the conversion in flight finish, with its result stored. No further conversion is started, and busy then drops.
- R8: Address 1 holds the priority channel in bits[3:0] and a priority start strobe in bit8. A priority start converts that channel once in any mode and writes the result to address 3. It then pulses `irq_priority`, sets priority done (cleared by a status read) and clears priority busy.
- R9: A priority request raised during a normal conversion waits for that conversion to finish. It is then issued before the next normal conversion, and the normal sequence resumes at the same slot and sweep position.
- R10: A start strobe while busy is 1 is ignored and does not reset the slot or sweep position. A priority strobe while priority busy is 1 is ignored.
- R11: `irq_norm` and `irq_priority` are single-cycle pulses.
- R12: `conv_start` is a single-cycle pulse, and no new `conv_start` is issued until the previous conversion has returned `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| conv_start | output | 1 | Starts one conversion |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 10 | Conversion result |
| irq_norm | output | 1 | Normal group complete pulse |
| irq_priority | output | 1 | Priority conversion complete pulse |

## Verification
Two collisions matter. The first is a status read that clears eoc landing in the very cycle a group completes. The bench waits for the rising edge of `conv_done` and raises the status read in that same cycle. The returned value must show eoc still clear, and a following read must show it set and then clear it. The second is a priority request arriving while a repeat run has a conversion in flight. The scoreboard's channel queue fixes the exact issue order, and the slot contents show that the normal rotation continued unbroken around the inserted conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_e;

  // Number of fixed-channel results that form one interrupt group.
  function automatic int unsigned grp_len(input logic rep, input logic [1:0] pace);
    if (!rep) return 1;
    case (pace)
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer import adc_seq_pkg::*; #(
  parameter  int NSLOT  = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              rep,
  input  logic [1:0]        pace,
  output logic [SLOT_W-1:0] slot,
  output logic              group_end
);

  logic [SLOT_W-1:0] slot_q;

  assign slot      = slot_q;
  assign group_end = advance && (32'(slot_q) == grp_len(rep, pace) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot_q <= '0;
    else if (restart)    slot_q <= '0;
    else if (group_end)  slot_q <= '0;
    else if (advance)    slot_q <= slot_q + 1'b1;
  end

  // R4: after a group closes, the next result lands in slot 0
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> (slot_q == '0));

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter  int NSLOT  = 8,
  parameter  int RES_W  = 10,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [RES_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [RES_W-1:0]  rd_data
);

  logic [RES_W-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q[g] <= '0;
      else if (wr_en && wr_idx == SLOT_W'(g))     slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter  int NSLOT  = 8,
  parameter  int RES_W  = 10,
  parameter  int CH_W   = 4,
  parameter  int DATA_W = 16,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq_norm,
  output logic              irq_priority
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PRES = ADDR_W'(3);
  localparam int GO_BIT = 8;

  function automatic logic [CH_W-1:0] sweep_top(input logic [CH_W-1:0] c);
    if (32'(c) > 32'(NSLOT - 1)) return CH_W'(NSLOT - 1);
    return c;
  endfunction

  seq_state_e        state_q;
  logic              mode_scan_q, mode_rep_q, rep_run_q;
  logic [1:0]        pace_q;
  logic [CH_W-1:0]   ch_q, prio_ch_q, sweep_q, conv_ch_q;
  logic              busy_q, eoc_q, prio_pend_q, prio_done_q, cur_prio_q;
  logic              conv_start_q, irq_norm_q, irq_prio_q;
  logic [RES_W-1:0]  prio_res_q;

  // Named events, shared by the logic and the assertions.
  logic ctrl_wr, launch, prio_wr, prio_accept, stat_rd, prio_busy;
  logic issue_prio, issue_norm, norm_done, prio_done_ev;
  logic sweep_last, pace_end, grp_end, stop_run;
  logic [SLOT_W-1:0] pace_slot, wr_slot;
  logic [RES_W-1:0]  slot_rd;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:GO_BIT+1];

  assign ctrl_wr      = reg_wr && reg_addr == A_CTRL;
  assign launch       = ctrl_wr && reg_wdata[GO_BIT] && !busy_q;
  assign prio_wr      = reg_wr && reg_addr == A_PRIO;
  assign prio_busy    = prio_pend_q || (state_q == SEQ_WAIT && cur_prio_q);
  assign prio_accept  = prio_wr && reg_wdata[GO_BIT] && !prio_busy;
  assign stat_rd      = reg_rd && reg_addr == A_STAT;
  assign issue_prio   = state_q == SEQ_IDLE && prio_pend_q;
  assign issue_norm   = state_q == SEQ_IDLE && !prio_pend_q && busy_q;
  assign norm_done    = state_q == SEQ_WAIT && conv_done && !cur_prio_q;
  assign prio_done_ev = state_q == SEQ_WAIT && conv_done && cur_prio_q;
  assign sweep_last   = sweep_q == sweep_top(ch_q);
  assign grp_end      = mode_scan_q ? (norm_done && sweep_last) : pace_end;
  assign stop_run     = norm_done &&
                        (rep_run_q ? !mode_rep_q : (!mode_scan_q || sweep_last));
  assign wr_slot      = mode_scan_q ? sweep_q[SLOT_W-1:0] : pace_slot;

  adc_seq_pacer #(.NSLOT(NSLOT)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (launch),
    .advance  (norm_done && !mode_scan_q),
    .rep      (rep_run_q),
    .pace     (pace_q),
    .slot     (pace_slot),
    .group_end(pace_end)
  );

  adc_seq_results #(.NSLOT(NSLOT), .RES_W(RES_W)) u_results (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (norm_done),
    .wr_idx (wr_slot),
    .wr_data(conv_result),
    .rd_idx (reg_addr[SLOT_W-1:0]),
    .rd_data(slot_rd)
  );

  // Configuration fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_scan_q <= 1'b0;
      mode_rep_q  <= 1'b0;
      pace_q      <= '0;
      ch_q        <= '0;
      prio_ch_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_scan_q <= reg_wdata[0];
        mode_rep_q  <= reg_wdata[1];
        pace_q      <= reg_wdata[3:2];
        ch_q        <= reg_wdata[4 +: CH_W];
      end
      if (prio_wr) prio_ch_q <= reg_wdata[CH_W-1:0];
    end
  end

  // Issue / wait sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      conv_start_q <= 1'b0;
      conv_ch_q    <= '0;
      cur_prio_q   <= 1'b0;
    end else if (state_q == SEQ_IDLE) begin
      if (issue_prio || issue_norm) begin
        state_q      <= SEQ_WAIT;
        conv_start_q <= 1'b1;
        cur_prio_q   <= issue_prio;
        conv_ch_q    <= issue_prio ? prio_ch_q : (mode_scan_q ? sweep_q : ch_q);
      end
    end else begin
      conv_start_q <= 1'b0;
      if (conv_done) state_q <= SEQ_IDLE;
    end
  end

  // Run state, sweep position and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      rep_run_q   <= 1'b0;
      sweep_q     <= '0;
      eoc_q       <= 1'b0;
      prio_pend_q <= 1'b0;
      prio_done_q <= 1'b0;
      prio_res_q  <= '0;
      irq_norm_q  <= 1'b0;
      irq_prio_q  <= 1'b0;
    end else begin
      if (launch) begin
        busy_q    <= 1'b1;
        rep_run_q <= reg_wdata[1];
        sweep_q   <= '0;
      end else begin
        if (stop_run) busy_q <= 1'b0;
        if (norm_done && mode_scan_q) sweep_q <= sweep_last ? '0 : sweep_q + 1'b1;
      end
      if (grp_end)      eoc_q <= 1'b1;
      else if (stat_rd) eoc_q <= 1'b0;
      if (prio_accept)     prio_pend_q <= 1'b1;
      else if (issue_prio) prio_pend_q <= 1'b0;
      if (prio_done_ev) begin
        prio_done_q <= 1'b1;
        prio_res_q  <= conv_result;
      end else if (stat_rd) prio_done_q <= 1'b0;
      irq_norm_q <= grp_end;
      irq_prio_q <= prio_done_ev;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1]) reg_rdata = DATA_W'(slot_rd);
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata = DATA_W'({ch_q, pace_q, mode_rep_q, mode_scan_q});
        A_PRIO:  reg_rdata = DATA_W'(prio_ch_q);
        A_STAT:  reg_rdata = DATA_W'({prio_done_q, prio_busy, eoc_q, busy_q});
        A_PRES:  reg_rdata = DATA_W'(prio_res_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign conv_start   = conv_start_q;
  assign conv_ch      = conv_ch_q;
  assign irq_norm     = irq_norm_q;
  assign irq_priority = irq_prio_q;

  // R11: interrupt outputs last one cycle
  p_norm_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |=> !irq_norm);
  p_prio_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_priority |=> !irq_priority);
  // R6: eoc is raised together with the normal interrupt
  p_eoc_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> eoc_q);
  // R12: start strobe is one cycle wide
  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R12: nothing new is issued while a result is outstanding
  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && !conv_done) |=> !conv_start);
  // R7: busy only falls right after a normal conversion returned
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(norm_done));
  // R5: busy holds between conversions of a run
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !norm_done) |=> busy_q);
  // R9: a pending priority request is the next thing issued
  p_prio_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && prio_pend_q) |=> (conv_start && cur_prio_q));
  // R8: priority completion leaves done set and busy clear
  p_prio_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_priority |-> (prio_done_q && !prio_busy));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam logic [3:0] A_CTRL = 4'd0, A_PRIO = 4'd1, A_STAT = 4'd2, A_PRES = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic        irq_norm, irq_priority;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .irq_norm(irq_norm), .irq_priority(irq_priority)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_started = 0, n_irq = 0, n_pirq = 0, lat = 3;
  string cur_req = "R1";
  logic [3:0] exp_q[$];

  function automatic logic [9:0] mk(input logic [3:0] ch, input int k);
    logic [31:0] kk = k;
    return {ch, kk[5:0]};
  endfunction

  function automatic logic [15:0] cw(input int ch, input int pace, input bit rep,
                                     input bit scan, input bit go);
    logic [31:0] c = ch, p = pace;
    return 16'({go, c[3:0], p[1:0], rep, scan});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); peek(A_STAT, d);
      if (!d[0] && !d[2]) break;
    end
  endtask

  // Launch a run, optionally inject one write at the inj_at-th start,
  // then clear the rep bit once n conversions have started.
  task automatic run_stop(input logic [15:0] w, input int n, input int inj_at,
                          input logic [3:0] inj_a, input logic [15:0] inj_d,
                          output int gaps);
    int base = n_started;
    bit injd = 0;
    logic [15:0] d;
    gaps = 0;
    wr(A_CTRL, w | 16'h100);
    for (int i = 0; i < 20000 && n_started < base + n; i++) begin
      @(negedge clk); #2 peek(A_STAT, d);
      if (!d[0]) gaps++;
      if (inj_at > 0 && !injd && n_started >= base + inj_at) begin
        wr(inj_a, inj_d); injd = 1;
      end
    end
    wr(A_CTRL, w & ~16'h0002);
    wait_idle();
    chk(n_started == base + n, "R7 conversions before stop", n_started - base, n);
  endtask

  // Converter model
  initial begin
    logic [3:0] ch;
    int k = 0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        ch = conv_ch;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (conv_start) chk(0, "R12 start while outstanding", 1, 0);
        end
        conv_result = mk(ch, k); k++;
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    bit pn = 0, pp = 0, ps = 0;
    logic [3:0] e;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        n_started++;
        if (exp_q.size() == 0) chk(0, {cur_req, " unexpected conversion"}, conv_ch, -1);
        else begin
          e = exp_q.pop_front();
          chk(conv_ch == e, {cur_req, " conversion channel"}, conv_ch, e);
        end
        if (ps) chk(0, "R12 start pulse width", 2, 1);
      end
      if (irq_norm) begin n_irq++; if (pn) chk(0, "R11 irq_norm width", 2, 1); end
      if (irq_priority) begin n_pirq++; if (pp) chk(0, "R11 irq_priority width", 2, 1); end
      pn = irq_norm; pp = irq_priority; ps = conv_start;
    end
  end

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int b, i0, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(A_STAT, d);
    chk(d == 0, "R1 status after reset", d, 0);
    chk(!irq_norm && !irq_priority && !conv_start, "R1 outputs after reset", 1, 0);

    // R1: fixed single
    cur_req = "R1"; b = n_started; i0 = n_irq; exp_q.push_back(4'd5);
    wr(A_CTRL, cw(5, 0, 0, 0, 1)); wait_idle();
    peek(4'd8, d); chk(d == 16'(mk(5, b)), "R1 slot0", d, mk(5, b));
    chk(n_irq == i0 + 1, "R1 irq count", n_irq - i0, 1);
    peek(A_CTRL, d); chk(d == 16'h0050, "R1 control readback", d, 16'h0050);
    rd(A_STAT, d); chk(d[1] == 1'b1, "R6 eoc set", d[1], 1);
    rd(A_STAT, d); chk(d[1] == 1'b0, "R6 eoc cleared by read", d[1], 0);

    // R2: single sweep 0..3
    cur_req = "R2"; b = n_started; i0 = n_irq;
    for (int c = 0; c < 4; c++) exp_q.push_back(4'(c));
    wr(A_CTRL, cw(3, 0, 0, 1, 1)); wait_idle();
    for (int c = 0; c < 4; c++) begin
      peek(4'(8 + c), d); chk(d == 16'(mk(4'(c), b + c)), "R2 slot by channel", d, mk(4'(c), b + c));
    end
    chk(n_irq == i0 + 1, "R2 one irq per sweep", n_irq - i0, 1);

    // R3 / R7: fixed repeat, pacing 00
    cur_req = "R3"; b = n_started; i0 = n_irq;
    repeat (3) exp_q.push_back(4'd2);
    run_stop(cw(2, 0, 1, 0, 0), 3, 0, A_CTRL, 16'h0, g);
    peek(4'd8, d); chk(d == 16'(mk(2, b + 2)), "R3 slot0 overwritten", d, mk(2, b + 2));
    chk(n_irq == i0 + 3, "R3 irq per result", n_irq - i0, 3);
    peek(A_STAT, d); chk(d[0] == 1'b0, "R7 busy dropped", d[0], 0);

    // R4: pacing 01, six results
    cur_req = "R4"; b = n_started; i0 = n_irq;
    repeat (6) exp_q.push_back(4'd6);
    run_stop(cw(6, 1, 1, 0, 0), 6, 0, A_CTRL, 16'h0, g);
    peek(4'd8, d);  chk(d == 16'(mk(6, b + 4)), "R4 slot0 wrapped", d, mk(6, b + 4));
    peek(4'd9, d);  chk(d == 16'(mk(6, b + 5)), "R4 slot1 wrapped", d, mk(6, b + 5));
    peek(4'd11, d); chk(d == 16'(mk(6, b + 3)), "R4 slot3", d, mk(6, b + 3));
    chk(n_irq == i0 + 1, "R4 irq per four", n_irq - i0, 1);

    // R4: pacing 10, nine results
    b = n_started; i0 = n_irq;
    repeat (9) exp_q.push_back(4'd1);
    run_stop(cw(1, 2, 1, 0, 0), 9, 0, A_CTRL, 16'h0, g);
    peek(4'd8, d);  chk(d == 16'(mk(1, b + 8)), "R4 slot0 after eight", d, mk(1, b + 8));
    peek(4'd15, d); chk(d == 16'(mk(1, b + 7)), "R4 slot7", d, mk(1, b + 7));
    chk(n_irq == i0 + 1, "R4 irq per eight", n_irq - i0, 1);

    // R5: repeat sweep 0..2, seven results
    cur_req = "R5"; b = n_started; i0 = n_irq;
    for (int c = 0; c < 7; c++) exp_q.push_back(4'(c % 3));
    run_stop(cw(2, 0, 1, 1, 0), 7, 0, A_CTRL, 16'h0, g);
    chk(g == 0, "R5 busy held during run", g, 0);
    chk(n_irq == i0 + 2, "R5 irq per sweep", n_irq - i0, 2);
    peek(4'd8, d);  chk(d == 16'(mk(0, b + 6)), "R5 slot0", d, mk(0, b + 6));
    peek(4'd10, d); chk(d == 16'(mk(2, b + 5)), "R5 slot2", d, mk(2, b + 5));

    // R6: status read in the completion cycle
    cur_req = "R6"; rd(A_STAT, d);
    exp_q.push_back(4'd4);
    wr(A_CTRL, cw(4, 0, 0, 0, 1));
    @(posedge conv_done); #1 reg_addr = A_STAT; reg_rd = 1'b1;
    #1 d = reg_rdata;
    chk(d[1] == 1'b0, "R6 eoc before set", d[1], 0);
    @(negedge clk); reg_rd = 1'b0;
    rd(A_STAT, d); chk(d[1] == 1'b1, "R6 set wins over read", d[1], 1);
    rd(A_STAT, d); chk(d[1] == 1'b0, "R6 cleared next read", d[1], 0);

    // R8: priority conversion while idle
    cur_req = "R8"; b = n_started; i0 = n_pirq;
    exp_q.push_back(4'd9);
    wr(A_PRIO, 16'h0109); wait_idle();
    peek(A_PRES, d); chk(d == 16'(mk(9, b)), "R8 priority result", d, mk(9, b));
    chk(n_pirq == i0 + 1, "R8 priority irq", n_pirq - i0, 1);
    rd(A_STAT, d); chk(d[3:2] == 2'b10, "R8 done set, busy clear", d[3:2], 2);
    rd(A_STAT, d); chk(d[3] == 1'b0, "R8 done cleared by read", d[3], 0);

    // R9: priority during fixed repeat (pacing 01)
    cur_req = "R9"; lat = 6; b = n_started; i0 = n_irq;
    exp_q.push_back(4'd3); exp_q.push_back(4'd3); exp_q.push_back(4'd12);
    repeat (3) exp_q.push_back(4'd3);
    run_stop(cw(3, 1, 1, 0, 0), 6, 2, A_PRIO, 16'h010C, g);
    peek(A_PRES, d);  chk(d == 16'(mk(12, b + 2)), "R9 priority result", d, mk(12, b + 2));
    peek(4'd10, d);   chk(d == 16'(mk(3, b + 3)), "R9 slot2 resumed", d, mk(3, b + 3));
    peek(4'd8, d);    chk(d == 16'(mk(3, b + 5)), "R9 slot0 wrapped", d, mk(3, b + 5));
    chk(n_irq == i0 + 1, "R9 normal group intact", n_irq - i0, 1);
    lat = 3;

    // R10: start strobe while busy
    cur_req = "R10"; b = n_started;
    for (int c = 0; c < 4; c++) exp_q.push_back(4'(c % 2));
    run_stop(cw(1, 0, 1, 1, 0), 4, 3, A_CTRL, cw(1, 0, 1, 1, 1), g);
    peek(4'd9, d); chk(d == 16'(mk(1, b + 3)), "R10 sweep not restarted", d, mk(1, b + 3));

    chk(exp_q.size() == 0, "R12 all expected conversions issued", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule